// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides, for every received CAN frame, whether the frame should be kept. The receive path presents the frame's identifier, its extended-format flag, its remote flag, its data length code and its first two data bytes together with a one-cycle valid strobe. One clock later the block returns a decision strobe carrying accept or reject. Bit-level reception, the receive store and bus timing live elsewhere.

Software sets the filter up while the controller sits in reset mode. It writes eight staging bytes (four code bytes and four mask bytes) and chooses a filter organisation: one wide filter, two narrower filters, or a legacy basic filter that uses one code byte and one mask byte. When the controller leaves reset mode, the staging bytes and the mode choice are copied into a working configuration. That copy stays frozen for as long as the controller operates.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are 0, the controller is in reset mode, and all staging and working configuration bytes are 0.
- R2: A frame strobed while `run` is 1, and was already 1 at the previous clock edge, yields `dec_valid`=1 exactly one cycle later. A frame strobed in reset mode yields no decision. `dec_accept` is never 1 without `dec_valid`.
- R3: In every mode, a mask bit of 1 makes the corresponding code bit a don't-care. A mask bit of 0 requires the frame bit to equal the code bit.
- R4: Single mode (`mode_single`=1, `mode_basic`=0), extended frame: ID[28:0] is compared with {byte0, byte1, byte2, byte3[7:3]}, and the remote flag with byte3[2]. The masks are bytes 4..7 in the same positions. No data byte is checked.
- R5: Single mode, standard frame (identifier in ID[10:0]): ID[10:0] is compared with {byte0, byte1[7:5]}, and the remote flag with byte1[4]. The masks are {byte4, byte5[7:5]} and byte5[4].
- R6: Single mode, standard frame that passed R5: a remote frame or a frame with DLC 0 is accepted. Otherwise data byte 0 must match byte2 under mask byte6. When DLC is 2 or more, data byte 1 must also match byte3 under mask byte7.
- R7: Dual mode (`mode_single`=0, `mode_basic`=0), extended frame: filter 1 compares ID[28:13] with {byte0, byte1} under {byte4, byte5}. Filter 2 compares the same bits with {byte2, byte3} under {byte6, byte7}. The frame is accepted if either filter hits, and the remote flag is not checked.
- R8: Dual mode, standard frame, filter 1: ID[10:0] and the remote flag are checked against {byte0, byte1[7:5]} and byte1[4], masked by {byte5... see below} {byte4, byte5[7:5]} and byte5[4]. Data byte 0 is also checked, whatever the DLC, against {byte1[3:0], byte3[3:0]} under {byte5[3:0], byte7[3:0]}.
- R9: Dual mode, standard frame, filter 2: ID[10:0] and the remote flag are checked against {byte2, byte3[7:5]} and byte3[4], masked by {byte6, byte7[7:5]} and byte7[4]. No data is checked. The frame is accepted if filter 1 or filter 2 hits.
- R10: Basic mode (`mode_basic`=1, which overrides `mode_single`): a standard frame is accepted when ID[10:3] matches byte0 under mask byte4. The remote flag and the data are ignored, and every extended frame is rejected.
- R11: Staging writes are taken only while `run`=0. The staging bytes and both mode inputs are copied on the first clock edge at which `run` is 1 after being 0. The working configuration then stays constant while `run` remains 1, and changes on `mode_*` during that time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | 1 = operating mode, 0 = reset mode |
| cfg_wr | input | 1 | Staging byte write strobe |
| cfg_sel | input | 3 | Staging byte index 0..7 (0..3 code, 4..7 mask) |
| cfg_data | input | 8 | Staging byte value |
| mode_single | input | 1 | 1 = single filter, 0 = dual filter |
| mode_basic | input | 1 | 1 = basic one-byte filter |
| frm_valid | input | 1 | Frame present strobe |
| frm_ext | input | 1 | 1 = extended (29-bit) identifier |
| frm_rtr | input | 1 | 1 = remote frame |
| frm_id | input | 29 | Identifier (standard frames use [10:0]) |
| frm_dlc | input | 4 | Data length code |
| frm_d0 | input | 8 | First data byte |
| frm_d1 | input | 8 | Second data byte |
| dec_valid | output | 1 | Decision strobe, one cycle after the frame |
| dec_accept | output | 1 | 1 = keep the frame |

## Verification
The assertions check on every cycle that the decision follows a strobe taken in operating mode, that accept never appears without valid, that extended frames never pass in basic mode, and that the working configuration and staging bytes stay frozen while the controller runs. Whether each bit-field layout is right can only be shown by the bench's scenarios: random configurations and frames are compared with an independent reference model, and directed cases cover the data-length corners of the single standard filter, the data-nibble part of dual filter 1, and the ignored writes during operation.

// File: rtl/acf_pkg.sv
package acf_pkg;
    localparam int CFG_BYTES = 8;
    localparam int BYTE_W    = 8;
    localparam int ID_W      = 29;
    localparam int STD_W     = 11;
    localparam int DLC_W     = 4;
    localparam int SEL_W     = $clog2(CFG_BYTES);

    typedef struct packed {
        logic [CFG_BYTES-1:0][BYTE_W-1:0] b;
        logic                             single;
        logic                             basic;
    } acf_cfg_t;

    typedef struct packed {
        logic              ext;
        logic              rtr;
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [BYTE_W-1:0] d0;
        logic [BYTE_W-1:0] d1;
    } acf_frame_t;

    function automatic logic hit_under(input logic [31:0] val,
                                       input logic [31:0] code,
                                       input logic [31:0] mask);
        return ((val ^ code) & ~mask) == 32'd0;
    endfunction
endpackage

// File: rtl/acf_cfg_store.sv
module acf_cfg_store
    import acf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [BYTE_W-1:0]     wr_byte,
    input  logic                  mode_single,
    input  logic                  mode_basic,
    output acf_cfg_t              cfg_o,
    output logic                  running_o
);
    typedef struct packed {
        logic [CFG_BYTES-1:0][BYTE_W-1:0] stage;
        acf_cfg_t                         work;
        logic                             run;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run && wr_en) begin
            s_d.stage[wr_sel] = wr_byte;
        end
        if (run && !s_q.run) begin
            s_d.work.b      = s_q.stage;
            s_d.work.single = mode_single;
            s_d.work.basic  = mode_basic;
        end
        s_d.run = run;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_o     = s_q.work;
    assign running_o = s_q.run;

    // R11: working configuration frozen while operating
    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && $past(s_q.run)) |-> $stable(s_q.work));

    // R11: staging bytes ignore writes in operating mode
    p_stage_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(s_q.stage));
endmodule

// File: rtl/acf_match.sv
module acf_match
    import acf_pkg::*;
(
    input  acf_cfg_t   cfg,
    input  acf_frame_t frm,
    output logic       hit
);
    localparam int NFILT = 2;
    localparam int HI_W  = 2 * BYTE_W;
    localparam int LO_ID = ID_W - HI_W;
    localparam int NIB   = BYTE_W / 2;

    logic [NFILT-1:0] dual_hit;
    logic single_ext, single_std_id, single_std_data, basic_hit;

    // Single filter, extended layout (R4)
    always_comb begin
        single_ext =
            hit_under(32'({cfg.b[0], cfg.b[1], cfg.b[2], cfg.b[3][7:3]}),
                      32'(frm.id),
                      32'({cfg.b[4], cfg.b[5], cfg.b[6], cfg.b[7][7:3]})) &&
            hit_under(32'(frm.rtr), 32'(cfg.b[3][2]), 32'(cfg.b[7][2]));
    end

    // Single filter, standard layout with data bytes (R5, R6)
    always_comb begin
        single_std_id =
            hit_under(32'(frm.id[STD_W-1:0]),
                      32'({cfg.b[0], cfg.b[1][7:5]}),
                      32'({cfg.b[4], cfg.b[5][7:5]})) &&
            hit_under(32'(frm.rtr), 32'(cfg.b[1][4]), 32'(cfg.b[5][4]));
        if (frm.rtr || frm.dlc == '0) begin
            single_std_data = 1'b1;
        end else begin
            single_std_data = hit_under(32'(frm.d0), 32'(cfg.b[2]), 32'(cfg.b[6]));
            if (frm.dlc >= DLC_W'(2)) begin
                single_std_data = single_std_data &&
                    hit_under(32'(frm.d1), 32'(cfg.b[3]), 32'(cfg.b[7]));
            end
        end
    end

    // Dual filters (R7, R8, R9)
    for (genvar g = 0; g < NFILT; g++) begin : g_dual
        localparam int CI = 2 * g;
        localparam int MI = CFG_BYTES / 2 + 2 * g;
        logic ext_hit, std_hit, data_hit;

        if (g == 0) begin : g_data
            always_comb begin
                data_hit = hit_under(32'(frm.d0),
                                     32'({cfg.b[1][NIB-1:0], cfg.b[3][NIB-1:0]}),
                                     32'({cfg.b[5][NIB-1:0], cfg.b[7][NIB-1:0]}));
            end
        end else begin : g_nodata
            always_comb data_hit = 1'b1;
        end

        always_comb begin
            ext_hit = hit_under(32'(frm.id[ID_W-1:LO_ID]),
                                32'({cfg.b[CI], cfg.b[CI+1]}),
                                32'({cfg.b[MI], cfg.b[MI+1]}));
            std_hit = hit_under(32'(frm.id[STD_W-1:0]),
                                32'({cfg.b[CI], cfg.b[CI+1][7:5]}),
                                32'({cfg.b[MI], cfg.b[MI+1][7:5]})) &&
                      hit_under(32'(frm.rtr), 32'(cfg.b[CI+1][4]),
                                32'(cfg.b[MI+1][4])) &&
                      data_hit;
            dual_hit[g] = frm.ext ? ext_hit : std_hit;
        end
    end

    // Basic one-byte filter (R10)
    always_comb begin
        basic_hit = !frm.ext &&
            hit_under(32'(frm.id[STD_W-1:STD_W-BYTE_W]), 32'(cfg.b[0]),
                      32'(cfg.b[CFG_BYTES/2]));
    end

    always_comb begin
        if (cfg.basic)       hit = basic_hit;
        else if (cfg.single) hit = frm.ext ? single_ext
                                           : (single_std_id && single_std_data);
        else                 hit = |dual_hit;
    end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import acf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_sel,
    input  logic [7:0]        cfg_data,
    input  logic              mode_single,
    input  logic              mode_basic,
    input  logic              frm_valid,
    input  logic              frm_ext,
    input  logic              frm_rtr,
    input  logic [28:0]       frm_id,
    input  logic [3:0]        frm_dlc,
    input  logic [7:0]        frm_d0,
    input  logic [7:0]        frm_d1,
    output logic              dec_valid,
    output logic              dec_accept
);
    typedef struct packed {
        logic valid;
        logic accept;
    } dec_t;

    acf_cfg_t   cfg;
    acf_frame_t frm;
    logic       running, hit;
    dec_t       dec_d, dec_q;

    assign frm = '{ext: frm_ext, rtr: frm_rtr, id: frm_id, dlc: frm_dlc,
                   d0: frm_d0, d1: frm_d1};

    acf_cfg_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .wr_en      (cfg_wr),
        .wr_sel     (cfg_sel),
        .wr_byte    (cfg_data),
        .mode_single(mode_single),
        .mode_basic (mode_basic),
        .cfg_o      (cfg),
        .running_o  (running)
    );

    acf_match u_match (
        .cfg(cfg),
        .frm(frm),
        .hit(hit)
    );

    always_comb begin
        dec_d        = '0;
        dec_d.valid  = frm_valid && running;
        dec_d.accept = frm_valid && running && hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;

    // R2: accept only comes with a decision strobe
    p_accept_has_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);

    // R2: a decision follows a frame strobe taken in operating mode
    p_decision_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(frm_valid && running));

    // R2: no strobe, no decision
    p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !dec_valid);

    // R10: extended frames never pass the basic filter
    p_basic_ext_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && running && cfg.basic && frm_ext) |=> !dec_accept);
endmodule

// File: tb/can_accept_filter_test.sv
module can_accept_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0, cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_data = '0;
    logic        mode_single = 1'b0, mode_basic = 1'b0;
    logic        frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [7:0]  frm_d0 = '0, frm_d1 = '0;
    logic        dec_valid, dec_accept;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    can_accept_filter uut (.*);

    function automatic logic [7:0] by(input logic [63:0] c, input int k);
        return c[8*k +: 8];
    endfunction

    function automatic bit cmp(input logic [31:0] v, input logic [31:0] c,
                               input logic [31:0] m);
        for (int i = 0; i < 32; i++)
            if (!m[i] && (v[i] != c[i])) return 1'b0;
        return 1'b1;
    endfunction

    // Reference decision computed from the requirement text
    function automatic bit ref_acc(input logic [63:0] c, input bit single,
                                   input bit basic, input bit ext, input bit rtr,
                                   input logic [28:0] id, input logic [3:0] dlc,
                                   input logic [7:0] d0, input logic [7:0] d1);
        logic [31:0] cc, mm;
        bit f1, f2;
        if (basic) begin
            if (ext) return 1'b0;
            return cmp({24'd0, id[10:3]}, {24'd0, by(c,0)}, {24'd0, by(c,4)});
        end
        if (single) begin
            if (ext) begin
                cc = {by(c,0), by(c,1), by(c,2), by(c,3)};
                mm = {by(c,4), by(c,5), by(c,6), by(c,7)};
                return cmp({id, 3'b000}, {cc[31:3], 3'b000}, {mm[31:3], 3'b111}) &&
                       cmp({31'd0, rtr}, {31'd0, cc[2]}, {31'd0, mm[2]});
            end
            if (!cmp({21'd0, id[10:0]}, {21'd0, by(c,0), by(c,1)[7:5]},
                     {21'd0, by(c,4), by(c,5)[7:5]})) return 1'b0;
            if (!cmp({31'd0, rtr}, {31'd0, by(c,1)[4]}, {31'd0, by(c,5)[4]})) return 1'b0;
            if (rtr || dlc == 0) return 1'b1;
            if (!cmp({24'd0, d0}, {24'd0, by(c,2)}, {24'd0, by(c,6)})) return 1'b0;
            if (dlc < 2) return 1'b1;
            return cmp({24'd0, d1}, {24'd0, by(c,3)}, {24'd0, by(c,7)});
        end
        if (ext) begin
            f1 = cmp({16'd0, id[28:13]}, {16'd0, by(c,0), by(c,1)}, {16'd0, by(c,4), by(c,5)});
            f2 = cmp({16'd0, id[28:13]}, {16'd0, by(c,2), by(c,3)}, {16'd0, by(c,6), by(c,7)});
            return f1 || f2;
        end
        f1 = cmp({20'd0, id[10:0], rtr}, {20'd0, by(c,0), by(c,1)[7:4]},
                 {20'd0, by(c,4), by(c,5)[7:4]}) &&
             cmp({24'd0, d0}, {24'd0, by(c,1)[3:0], by(c,3)[3:0]},
                 {24'd0, by(c,5)[3:0], by(c,7)[3:0]});
        f2 = cmp({20'd0, id[10:0], rtr}, {20'd0, by(c,2), by(c,3)[7:4]},
                 {20'd0, by(c,6), by(c,7)[7:4]});
        return f1 || f2;
    endfunction

    function automatic string tag_of(input bit single, input bit basic, input bit ext);
        if (basic)  return "R10";
        if (single) return ext ? "R4" : "R5";
        return ext ? "R7" : "R8";
    endfunction

    task automatic check(input string req, input logic act, input logic exp,
                         input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [63:0] c, input bit single, input bit basic);
        @(negedge clk);
        run = 1'b0;
        for (int k = 0; k < 8; k++) begin
            cfg_wr = 1'b1; cfg_sel = 3'(k); cfg_data = by(c, k);
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        mode_single = single; mode_basic = basic;
        run = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input bit ext, input bit rtr, input logic [28:0] id,
                        input logic [3:0] dlc, input logic [7:0] d0,
                        input logic [7:0] d1, input bit exp_v, input bit exp_a,
                        input string req);
        frm_valid = 1'b1; frm_ext = ext; frm_rtr = rtr; frm_id = id;
        frm_dlc = dlc; frm_d0 = d0; frm_d1 = d1;
        @(negedge clk);
        frm_valid = 1'b0;
        check(req, dec_valid, exp_v, "dec_valid");
        check(req, dec_accept, exp_a, "dec_accept");
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [63:0] c;
        bit sg, bs, ex, rt;
        logic [28:0] id;
        logic [3:0] dl;
        logic [7:0] a0, a1;
        void'($urandom(32'h5eed_c0de));

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", dec_valid, 1'b0, "dec_valid in reset");
        check("R1", dec_accept, 1'b0, "dec_accept in reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R2: frame in reset mode gives no decision; R1: all-zero config
        send(1'b0, 1'b0, 29'h0, 4'd0, 8'h0, 8'h0, 1'b0, 1'b0, "R2");
        run = 1'b1;
        @(negedge clk);
        // R1: zeroed dual config accepts a zero std frame with zero data
        send(1'b0, 1'b0, 29'h0, 4'd1, 8'h00, 8'h0, 1'b1, 1'b1, "R1");

        // R10: basic mode, code 0xA5 mask 0 in byte 0 / byte 4
        c = 64'h0;
        c[7:0] = 8'hA5;
        load_cfg(c, 1'b1, 1'b1);
        send(1'b0, 1'b1, {18'd0, 8'hA5, 3'b101}, 4'd3, 8'h11, 8'h22, 1'b1, 1'b1, "R10");
        send(1'b0, 1'b0, {18'd0, 8'hA4, 3'b000}, 4'd0, 8'h0, 8'h0, 1'b1, 1'b0, "R10");
        send(1'b1, 1'b0, {18'd0, 8'hA5, 3'b000}, 4'd0, 8'h0, 8'h0, 1'b1, 1'b0, "R10");
        // R11: writes and mode changes while running are ignored
        cfg_wr = 1'b1; cfg_sel = 3'd0; cfg_data = 8'h00;
        mode_basic = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        send(1'b0, 1'b0, {18'd0, 8'hA5, 3'b000}, 4'd0, 8'h0, 8'h0, 1'b1, 1'b1, "R11");
        send(1'b1, 1'b0, {18'd0, 8'hA5, 3'b000}, 4'd0, 8'h0, 8'h0, 1'b1, 1'b0, "R11");
        run = 1'b0; mode_basic = 1'b1;
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        send(1'b0, 1'b0, {18'd0, 8'hA5, 3'b000}, 4'd0, 8'h0, 8'h0, 1'b1, 1'b1, "R11");
        send(1'b0, 1'b0, 29'h0, 4'd0, 8'h0, 8'h0, 1'b1, 1'b0, "R11");

        // R6: single std, id 0x123 data-sensitive, code d0=0x5A d1=0xC3
        c = {8'h00, 8'h00, 8'h00, 8'h00, 8'hC3, 8'h5A, 8'h60, 8'h24};
        load_cfg(c, 1'b1, 1'b0);
        send(1'b0, 1'b0, 29'h123, 4'd0, 8'hFF, 8'hFF, 1'b1, 1'b1, "R6");
        send(1'b0, 1'b1, 29'h123, 4'd8, 8'hFF, 8'hFF, 1'b1, 1'b0, "R5");
        send(1'b0, 1'b0, 29'h123, 4'd1, 8'h5A, 8'hFF, 1'b1, 1'b1, "R6");
        send(1'b0, 1'b0, 29'h123, 4'd1, 8'h5B, 8'hC3, 1'b1, 1'b0, "R6");
        send(1'b0, 1'b0, 29'h123, 4'd2, 8'h5A, 8'hC2, 1'b1, 1'b0, "R6");
        send(1'b0, 1'b0, 29'h123, 4'd8, 8'h5A, 8'hC3, 1'b1, 1'b1, "R6");
        send(1'b0, 1'b0, 29'h122, 4'd0, 8'h0, 8'h0, 1'b1, 1'b0, "R5");
        // R3: open the low ID bit and d1 bit 0 in the masks
        c = {8'h01, 8'h00, 8'h20, 8'h00, 8'hC3, 8'h5A, 8'h60, 8'h24};
        load_cfg(c, 1'b1, 1'b0);
        send(1'b0, 1'b0, 29'h122, 4'd2, 8'h5A, 8'hC2, 1'b1, 1'b1, "R3");

        // R8/R9: dual std; filter1 id 0x123 d0 0x7B, filter2 id 0x456
        c = {8'h00, 8'h00, 8'h00, 8'h00, 8'hCB, 8'h8A, 8'h67, 8'h24};
        load_cfg(c, 1'b0, 1'b0);
        send(1'b0, 1'b0, 29'h123, 4'd0, 8'h7B, 8'h00, 1'b1, 1'b1, "R8");
        send(1'b0, 1'b0, 29'h123, 4'd0, 8'h7A, 8'h00, 1'b1, 1'b0, "R8");
        send(1'b0, 1'b0, 29'h456, 4'd0, 8'h00, 8'h00, 1'b1, 1'b1, "R9");
        send(1'b0, 1'b1, 29'h456, 4'd0, 8'h00, 8'h00, 1'b1, 1'b0, "R9");
        // R7: dual ext, ID[28:13] 0x2467 or 0x8ACB
        send(1'b1, 1'b1, {16'h2467, 13'h1ABC}, 4'd0, 8'h0, 8'h0, 1'b1, 1'b1, "R7");
        send(1'b1, 1'b0, {16'h8ACB, 13'h0001}, 4'd0, 8'h0, 8'h0, 1'b1, 1'b1, "R7");
        send(1'b1, 1'b0, {16'h8ACA, 13'h0001}, 4'd0, 8'h0, 8'h0, 1'b1, 1'b0, "R7");
        // R4: single ext, exact id 0x0ABCDEF1 data frame
        c = 64'h0;
        c[31:0] = {29'h0ABCDEF1, 3'b000} >> 0;
        c = {8'h00, 8'h00, 8'h00, 8'h00, c[7:0], c[15:8], c[23:16], c[31:24]};
        load_cfg(c, 1'b1, 1'b0);
        send(1'b1, 1'b0, 29'h0ABCDEF1, 4'd2, 8'h12, 8'h34, 1'b1, 1'b1, "R4");
        send(1'b1, 1'b1, 29'h0ABCDEF1, 4'd2, 8'h12, 8'h34, 1'b1, 1'b0, "R4");
        send(1'b1, 1'b0, 29'h0ABCDEF0, 4'd2, 8'h12, 8'h34, 1'b1, 1'b0, "R4");

        // Random configurations and frames against the reference (R3..R10)
        for (int cfgn = 0; cfgn < 40; cfgn++) begin
            for (int k = 0; k < 4; k++) begin
                c[8*k +: 8]     = 8'($urandom);
                c[8*(k+4) +: 8] = 8'($urandom | $urandom | $urandom);
            end
            sg = 1'($urandom); bs = ($urandom % 4) == 0;
            load_cfg(c, sg, bs);
            for (int f = 0; f < 30; f++) begin
                ex = 1'($urandom); rt = ($urandom % 4) == 0;
                if (ex) id = 29'($urandom);
                else    id = {18'd0, 11'($urandom)};
                dl = 4'($urandom % 9);
                a0 = 8'($urandom); a1 = 8'($urandom);
                if ($urandom % 2) begin
                    if (!ex) id[10:3] = by(c, 0);
                    a0 = by(c, 2);
                end
                send(ex, rt, id, dl, a0, a1, 1'b1,
                     ref_acc(c, sg, bs, ex, rt, id, dl, a0, a1), tag_of(sg, bs, ex));
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule